// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-facing side of a three-channel interval timer. A host reaches it through a 2-bit address, separate read and write strobes and an 8-bit data bus. Addresses 0 to 2 carry the count bytes of channels 0 to 2. Address 3 takes control words. The block turns these byte accesses into 16-bit count loads, per-channel mode settings and latched snapshots. It passes the counts, modes and BCD flags to counting logic that sits outside this block. It reads back that logic's live counts and output levels.

A control word configures one channel or latches its count. A read-back command can snapshot the count and the status of any set of channels in one write. Each channel has its own state: a write phase, a read phase, a latched count and a latched status. Channels therefore never disturb one another.

Top module: `tmr_host_if`

## Requirements
- R1: After reset every channel is in word access mode (code 3), operating mode 0 and binary counting. No latches are held and null-count is clear. ld_o and rdata_o are zero.
- R2: A write to address 3 with bits 7:6 = c (0..2) and bits 5:4 nonzero is a control word for channel c. Bits 5:4 are the access mode. Bits 3:1 are the operating mode, with codes 6 and 7 folded to 2 and 3. Bit 0 is BCD. mode_o and bcd_o show the new values from the cycle after the write.
- R3: A control word with nonzero access mode returns that channel's read phase and write phase to the low byte.
- R4: A data write to address c loads the count according to the access mode. Mode 1 loads {00,byte}. Mode 2 loads {byte,00}. Mode 3 holds the first byte as the low byte and loads {second,first} on the second write. In the cycle after the loading write, channel c's bit of ld_o pulses for one cycle and cnt_val_o holds the new count.
- R5: Null-count (status bit 6) is set in the cycle after a loading write. It clears in the cycle after loaded_i of that channel. When both happen in the same cycle, set wins.
- R6: With no latch held, a read of address c returns the live count. Mode 1 gives the low byte and mode 2 the high byte. Mode 3 alternates low then high, using that channel's read phase. A read of address 3 returns 0. rdata_o holds the byte from the cycle after rd_i.
- R7: A control word with access bits 0 captures that channel's live count. The following reads return it in the access mode current at capture: one byte for modes 1 and 2, low then high for mode 3. The latch is then released, and live reads resume without disturbing the read phase.
- R8: A count latch request is ignored while that channel still holds an unread latched count. A status latch request is ignored while an unread latched status is held.
- R9: A write to address 3 with bits 7:6 = 3 is a read-back command. Bit k+1 selects channel k. Bit 5 low latches the count and bit 4 low latches the status, for every selected channel at once.
- R10: The status byte is {out, null-count, access mode[1:0], operating mode[2:0], bcd} (bits 7 down to 0), taken at the moment of the command.
- R11: A read returns a held status first, then a held latched count, then the live count. Reading the status leaves a held latched count untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address (0..2 channel data, 3 control) |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| ld_o | output | 3 | Per-channel count load pulse |
| cnt_val_o | output | 48 | Per-channel 16-bit count value, channel 0 in the low bits |
| mode_o | output | 9 | Per-channel 3-bit operating mode |
| bcd_o | output | 3 | Per-channel BCD flag |
| null_o | output | 3 | Per-channel null-count flag |
| live_cnt_i | input | 48 | Per-channel live count from the counting logic |
| out_i | input | 3 | Per-channel OUT level |
| loaded_i | input | 3 | Per-channel pulse: the count has been taken into the counter |

## Verification
Every result of this block appears exactly one clock edge after the strobe that causes it. rdata_o, ld_o, cnt_val_o, mode_o, bcd_o and null-count all update at the edge that samples wr_i or rd_i. The bench drives strobes on the falling edge and holds them for one cycle. It then compares control outputs at the next falling edge, so each check lands half a cycle after the update it observes. Read results go through a queue. Each read pushes its expected byte and requirement tag. A monitor pops the entry at the falling edge that follows the sampling rising edge, so reads in back-to-back cycles each meet their own expectation.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef struct packed {
    logic cw_set;
    logic lat_cnt;
    logic lat_stat;
  } ch_evt_t;

  // codes 6 and 7 alias 2 and 3
  function automatic logic [2:0] fold_mode(logic [2:0] m);
    return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
  endfunction

endpackage

// File: rtl/tmr_cw_dec.sv
module tmr_cw_dec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output ch_evt_t [NUM_CH-1:0]  evt_o,
  output acc_e                  cw_acc_o,
  output logic [2:0]            cw_mode_o,
  output logic                  cw_bcd_o
);
  localparam logic [ADDR_W-1:0] CW_ADDR = '1;
  localparam logic [1:0]        RB_SEL  = 2'd3;

  logic       cw_wr;
  logic [1:0] sel;
  logic [NUM_CH-1:0] cw_vec;

  assign cw_wr     = wr_i && (addr_i == CW_ADDR);
  assign sel       = wdata_i[7:6];
  assign cw_acc_o  = acc_e'(wdata_i[5:4]);
  assign cw_mode_o = fold_mode(wdata_i[3:1]);
  assign cw_bcd_o  = wdata_i[0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit, rb_hit;
    assign hit    = cw_wr && (sel == 2'(c));
    assign rb_hit = cw_wr && (sel == RB_SEL) && wdata_i[c+1];
    assign evt_o[c].cw_set   = hit && (cw_acc_o != ACC_LATCH);
    assign evt_o[c].lat_cnt  = (hit && (cw_acc_o == ACC_LATCH)) || (rb_hit && !wdata_i[5]);
    assign evt_o[c].lat_stat = rb_hit && !wdata_i[4];
    assign cw_vec[c] = evt_o[c].cw_set;
  end

  // R2
  one_cw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(cw_vec));

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ch_evt_t           evt_i,
  input  acc_e              cw_acc_i,
  input  logic [2:0]        cw_mode_i,
  input  logic              cw_bcd_i,
  input  logic              wr_here_i,
  input  logic              rd_here_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  live_cnt_i,
  input  logic              out_i,
  input  logic              loaded_i,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              ld_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [2:0]        mode_o,
  output logic              bcd_o,
  output logic              null_o
);
  acc_e              acc_q;
  logic [2:0]        mode_q;
  logic              bcd_q, wr_hi_q, rd_hi_q, ld_q, null_q, stat_vld_q;
  logic [DATA_W-1:0] hold_q, stat_q;
  logic [CNT_W-1:0]  cnt_q, lat_q;
  acc_e              lat_mode_q;   // ACC_LATCH means no latched count
  logic              load_now;
  logic [CNT_W-1:0]  load_val;

  always_comb begin
    load_now = 1'b0;
    load_val = cnt_q;
    if (wr_here_i) begin
      unique case (acc_q)
        ACC_LO:   begin load_now = 1'b1; load_val = {{DATA_W{1'b0}}, wdata_i}; end
        ACC_HI:   begin load_now = 1'b1; load_val = {wdata_i, {DATA_W{1'b0}}}; end
        ACC_WORD: begin load_now = wr_hi_q; load_val = {wdata_i, hold_q}; end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_WORD;
      mode_q     <= '0;
      bcd_q      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      cnt_q      <= '0;
      ld_q       <= 1'b0;
      null_q     <= 1'b0;
      lat_mode_q <= ACC_LATCH;
      lat_q      <= '0;
      stat_vld_q <= 1'b0;
      stat_q     <= '0;
    end else begin
      ld_q <= load_now;
      if (load_now) cnt_q <= load_val;
      if (load_now) null_q <= 1'b1;
      else if (loaded_i) null_q <= 1'b0;

      if (wr_here_i && acc_q == ACC_WORD) begin
        if (!wr_hi_q) hold_q <= wdata_i;
        wr_hi_q <= ~wr_hi_q;
      end

      if (evt_i.cw_set) begin
        acc_q   <= cw_acc_i;
        mode_q  <= cw_mode_i;
        bcd_q   <= cw_bcd_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end

      if (evt_i.lat_cnt && lat_mode_q == ACC_LATCH) begin
        lat_q      <= live_cnt_i;
        lat_mode_q <= acc_q;
      end
      if (evt_i.lat_stat && !stat_vld_q) begin
        stat_q     <= {out_i, null_q, acc_q, mode_q, bcd_q};
        stat_vld_q <= 1'b1;
      end

      if (rd_here_i) begin
        if (stat_vld_q) begin
          stat_vld_q <= 1'b0;
        end else if (lat_mode_q != ACC_LATCH) begin
          lat_mode_q <= (lat_mode_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
        end else if (acc_q == ACC_WORD) begin
          rd_hi_q <= ~rd_hi_q;
        end
      end
    end
  end

  always_comb begin
    if (stat_vld_q)
      rd_byte_o = stat_q;
    else if (lat_mode_q != ACC_LATCH)
      rd_byte_o = (lat_mode_q == ACC_HI) ? lat_q[CNT_W-1:DATA_W] : lat_q[DATA_W-1:0];
    else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q))
      rd_byte_o = live_cnt_i[CNT_W-1:DATA_W];
    else
      rd_byte_o = live_cnt_i[DATA_W-1:0];
  end

  assign ld_o   = ld_q;
  assign cnt_o  = cnt_q;
  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;
  assign null_o = null_q;

  // R4
  byte_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_here_i && acc_q != ACC_WORD) |=> ld_q);
  // R3
  tog_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.cw_set |=> (!wr_hi_q && !rd_hi_q));
  // R5
  null_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_q |-> null_q);
  // R8
  lat_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_mode_q != ACC_LATCH && !rd_here_i) |=> $stable(lat_q));
  // R8
  stat_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_vld_q && !rd_here_i) |=> (stat_vld_q && $stable(stat_q)));
  // R11
  stat_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_here_i && stat_vld_q) |=> $stable(lat_mode_q));

endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [NUM_CH-1:0]       ld_o,
  output logic [NUM_CH*CNT_W-1:0] cnt_val_o,
  output logic [NUM_CH*3-1:0]     mode_o,
  output logic [NUM_CH-1:0]       bcd_o,
  output logic [NUM_CH-1:0]       null_o,
  input  logic [NUM_CH*CNT_W-1:0] live_cnt_i,
  input  logic [NUM_CH-1:0]       out_i,
  input  logic [NUM_CH-1:0]       loaded_i
);
  ch_evt_t [NUM_CH-1:0]           evt;
  acc_e                           cw_acc;
  logic [2:0]                     cw_mode;
  logic                           cw_bcd;
  logic [NUM_CH-1:0][DATA_W-1:0]  rd_byte;
  logic [DATA_W-1:0]              rd_sel, rdata_q;

  tmr_cw_dec #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .evt_o     (evt),
    .cw_acc_o  (cw_acc),
    .cw_mode_o (cw_mode),
    .cw_bcd_o  (cw_bcd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel_here;
    assign sel_here = (addr_i == ADDR_W'(c));
    tmr_chan #(.DATA_W(DATA_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[c]),
      .cw_acc_i   (cw_acc),
      .cw_mode_i  (cw_mode),
      .cw_bcd_i   (cw_bcd),
      .wr_here_i  (wr_i && sel_here),
      .rd_here_i  (rd_i && sel_here),
      .wdata_i    (wdata_i),
      .live_cnt_i (live_cnt_i[c*CNT_W +: CNT_W]),
      .out_i      (out_i[c]),
      .loaded_i   (loaded_i[c]),
      .rd_byte_o  (rd_byte[c]),
      .ld_o       (ld_o[c]),
      .cnt_o      (cnt_val_o[c*CNT_W +: CNT_W]),
      .mode_o     (mode_o[c*3 +: 3]),
      .bcd_o      (bcd_o[c]),
      .null_o     (null_o[c])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == ADDR_W'(c)) rd_sel = rd_byte[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_sel;
  end

  assign rdata_o = rdata_q;

  // R4
  ld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(ld_o));
  // R6
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

endmodule

// File: tb/tmr_host_if_bench.sv
module tmr_host_if_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  ld, bcd, nul;
  logic [47:0] cnt_val;
  logic [8:0]  mode;
  logic [47:0] live = '0;
  logic [2:0]  outl = '0, loaded = '0;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_host_if u_tmr_host_if (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .ld_o(ld), .cnt_val_o(cnt_val),
    .mode_o(mode), .bcd_o(bcd), .null_o(nul), .live_cnt_i(live),
    .out_i(outl), .loaded_i(loaded)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_q <= rd;

  // monitor: one result per read, due one edge after the strobe
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) chk("read-no-expect", rdata, 8'hxx);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic do_wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_rd(logic [1:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ld", ld, 3'b000);
    chk("R1 mode", mode, 9'd0);
    chk("R1 bcd", bcd, 3'b000);
    chk("R1 rdata", rdata, 8'h00);
    do_wr(3, 8'hE2);
    do_rd(0, 8'h30, "R1 R10 reset status");

    // R2 control words
    do_wr(3, 8'h35);
    chk("R2 mode ch0", mode[2:0], 3'd2);
    chk("R2 bcd ch0", bcd[0], 1'b1);
    do_wr(3, 8'h5C);
    chk("R2 mode6 fold ch1", mode[5:3], 3'd2);
    do_wr(3, 8'hAE);
    chk("R2 mode7 fold ch2", mode[8:6], 3'd3);

    // R4 loads
    do_wr(0, 8'h34);
    chk("R4 word first no load", ld, 3'b000);
    do_wr(0, 8'h12);
    chk("R4 word load pulse", ld, 3'b001);
    chk("R4 word value", cnt_val[15:0], 16'h1234);
    @(negedge clk);
    chk("R4 pulse one cycle", ld, 3'b000);
    do_wr(1, 8'hAB);
    chk("R4 lsb load", ld, 3'b010);
    chk("R4 lsb value", cnt_val[31:16], 16'h00AB);
    do_wr(2, 8'hCD);
    chk("R4 msb load", ld, 3'b100);
    chk("R4 msb value", cnt_val[47:32], 16'hCD00);

    // R5 null-count
    outl = 3'b001;
    do_wr(3, 8'hE2);
    do_rd(0, 8'hF5, "R5 R10 null set");
    loaded = 3'b001; @(negedge clk); loaded = 3'b000;
    chk("R5 null cleared", nul[0], 1'b0);
    do_wr(3, 8'hE2);
    do_rd(0, 8'hB5, "R5 status after load");

    // R6 live reads
    live = {16'hDEF0, 16'h9ABC, 16'h5678};
    do_rd(0, 8'h78, "R6 word lo");
    do_rd(0, 8'h56, "R6 word hi");
    do_rd(0, 8'h78, "R6 word lo again");
    do_rd(1, 8'hBC, "R6 lsb");
    do_rd(1, 8'hBC, "R6 lsb repeat");
    do_rd(2, 8'hDE, "R6 msb");
    do_rd(3, 8'h00, "R6 ctrl addr");

    // R3 phase reset
    do_wr(0, 8'h11);
    do_wr(3, 8'h35);
    do_rd(0, 8'h78, "R3 read phase reset");
    do_wr(0, 8'h22);
    chk("R3 write phase reset", ld, 3'b000);
    do_wr(0, 8'h33);
    chk("R3 reload value", cnt_val[15:0], 16'h3322);

    // R7 counter latch
    do_wr(3, 8'h00);
    live[15:0] = 16'h4321;
    do_rd(0, 8'h78, "R7 latched lo");
    do_rd(0, 8'h56, "R7 latched hi");
    do_rd(0, 8'h43, "R7 live after release");
    do_rd(0, 8'h21, "R7 live toggle");

    // R8 repeated latches ignored
    do_wr(3, 8'h40);
    live[31:16] = 16'h1111;
    do_wr(3, 8'h40);
    do_rd(1, 8'hBC, "R8 first count kept");
    do_rd(1, 8'h11, "R8 live after");
    outl[2] = 1'b1;
    do_wr(3, 8'hE8);
    outl[2] = 1'b0;
    do_wr(3, 8'hE8);
    do_rd(2, 8'hE6, "R8 first status kept");
    do_rd(2, 8'hDE, "R8 live after status");

    // R9 R11 multi-channel read-back
    outl = 3'b001;
    do_wr(3, 8'hC6);
    do_rd(0, 8'hF5, "R11 status first ch0");
    do_rd(0, 8'h21, "R9 latched lo ch0");
    do_rd(0, 8'h43, "R9 latched hi ch0");
    do_rd(1, 8'h54, "R11 status first ch1");
    do_rd(1, 8'h11, "R9 latched ch1");
    do_rd(2, 8'hDE, "R9 ch2 unselected");

    // R5 set wins over loaded
    loaded = 3'b010; @(negedge clk); loaded = 3'b000;
    do_wr(3, 8'hE4);
    do_rd(1, 8'h14, "R5 ch1 cleared");
    loaded = 3'b010;
    do_wr(1, 8'h55);
    loaded = 3'b000;
    do_wr(3, 8'hE4);
    do_rd(1, 8'h54, "R5 set wins");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule